// File: doc/BRIEF.md
# DRAM refresh scheduler

This block keeps every row of an asynchronous, 4-bit-wide DRAM inside its retention period. An interval timer posts one refresh obligation per interval. Obligations that cannot be served at once are held in a small backlog. While the backlog is non-empty the block requests the memory bus from the access sequencer. Once granted, it drives the row and column strobes through one complete refresh cycle and then pulses a completion flag.

Two refresh methods can be selected. In the first, the column strobe falls before the row strobe and the device steps its own row counter. In the second, the block drives an explicit row number on the address lines and pulses only the row strobe. The second method needs twice as many cycles per retention window, so its interval is half as long. Both intervals come from the window length, the row counts and the clock period.

The access sequencer grants only after it has closed its open page and finished precharge. It uses the urgent flag to hold back new accesses when the backlog is full.

Top module: `refsched_top`

## Requirements
- R1: A refresh obligation is posted every INT_CBR = WIN_NS/(CBR_ROWS*CLK_NS) cycles while `mode_i`=0 (internal-counter method) and every INT_ROR = WIN_NS/(ROR_ROWS*CLK_NS) cycles while `mode_i`=1 (explicit-row method). The interval counter starts at zero after reset.
- R2: The backlog `pending_o` counts from 0 to 7 and holds at 7 when a further obligation arrives. If an obligation and a completion fall in the same cycle, the count is unchanged.
- R3: `ref_req_o` is high exactly when `pending_o` is non-zero. `ref_urgent_o` is high exactly when `pending_o` is 7.
- R4: A refresh starts on the clock edge where the block is idle and both `ref_req_o` and `ref_gnt_i` are high. Strobes change in the following cycle. `ref_gnt_i` has no effect while a refresh is in progress or while there is no request.
- R5: Internal-counter refresh: `cas_n_o` is low with `ras_n_o` high for CSR_CYC cycles, then both are low for RAS_CYC cycles, then both are high for the precharge phase. `addr_oe_o` stays 0 throughout.
- R6: Explicit-row refresh: `addr_oe_o` is 1 and `addr_o` carries the row number with `ras_n_o` high for ASR_CYC cycles. Then `ras_n_o` is low for RAS_CYC cycles with the address still driven, then precharge follows. `cas_n_o` stays high throughout. `addr_o` is 0 whenever `addr_oe_o` is 0.
- R7: The precharge phase lasts max(RP_CYC, RC_CYC - RAS_CYC - min(CSR_CYC, ASR_CYC)) cycles, so every refresh occupies at least RC_CYC cycles.
- R8: `ref_done_o` is a one-cycle pulse in the last precharge cycle. The backlog drops by one at the following edge.
- R9: The explicit row number is 13 bits. It starts at 0, advances by one after each explicit-row refresh, wraps from 8191 to 0, and is not changed by internal-counter refreshes.
- R10: With `rst` high: `ras_n_o`=1, `cas_n_o`=1, `addr_oe_o`=0, `addr_o`=0, `ref_req_o`=0, `ref_urgent_o`=0, `ref_done_o`=0 and `pending_o`=0.
- R11: The method is latched when a refresh starts. A change of `mode_i` during a refresh does not alter that refresh's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Refresh method: 0 internal counter, 1 explicit row |
| ref_gnt_i | input | 1 | Bus grant from the access sequencer |
| ref_req_o | output | 1 | Bus request: refresh owed |
| ref_urgent_o | output | 1 | Backlog full, new accesses must wait |
| ref_done_o | output | 1 | Pulse: one refresh cycle completed |
| pending_o | output | 3 | Refreshes owed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_oe_o | output | 1 | Address lines driven by this block |
| addr_o | output | 13 | Row number for explicit-row refresh |

## Verification
The interval timer can post a new obligation in the same cycle that a refresh completes. The backlog must then stay where it was, neither rising nor falling. The bench provokes this in two ways. Random grants produce the clash sporadically. A long explicit-row run sets the interval equal to the length of one refresh plus its idle cycle, so ticks and completions line up on the same edge again and again. A cycle-level model built from the requirements predicts `pending_o`, the strobes and the row address on every cycle, and each cycle's outputs are compared against it.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CAS  = 3'd1,
        PH_ADR  = 3'd2,
        PH_RAS  = 3'd3,
        PH_PRE  = 3'd4
    } phase_e;

    typedef enum logic {
        METH_CBR = 1'b0,
        METH_ROR = 1'b1
    } method_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic addr_oe;
    } pins_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int interval(input int win_ns, input int rows, input int clk_ns);
        return win_ns / (rows * clk_ns);
    endfunction

    function automatic pins_t pins_of(input phase_e ph, input method_e m);
        pins_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, addr_oe: 1'b0};
        unique case (ph)
            PH_CAS: p.cas_n = 1'b0;
            PH_ADR: p.addr_oe = 1'b1;
            PH_RAS: begin
                p.ras_n   = 1'b0;
                p.cas_n   = (m == METH_ROR);
                p.addr_oe = (m == METH_ROR);
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer
    import refsched_pkg::*;
#(
    parameter int INT_CBR = 781,
    parameter int INT_ROR = 390
) (
    input  logic    clk,
    input  logic    rst,
    input  method_e meth,
    output logic    tick
);
    localparam int CW = $clog2(imax(INT_CBR, INT_ROR) + 1);
    localparam logic [CW-1:0] LAST_CBR = CW'(INT_CBR - 1);
    localparam logic [CW-1:0] LAST_ROR = CW'(INT_ROR - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Compare with >= so a switch to the shorter interval cannot overrun
    assign last = (meth == METH_ROR) ? LAST_ROR : LAST_CBR;
    assign tick = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          done,
    output logic [BW-1:0] count,
    output logic          req,
    output logic          urgent
);
    localparam logic [BW-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({tick, done})
                2'b10:   if (count != FULL) count <= count + 1'b1;
                2'b01:   if (count != '0)   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign req    = (count != '0);
    assign urgent = (count == FULL);
endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm
    import refsched_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int ASR_CYC = 1,
    parameter int RAS_CYC = 3,
    parameter int PRE_CYC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    gnt,
    input  method_e meth,
    output pins_t   pins,
    output logic    done,
    output logic    ror_done
);
    localparam int LONGEST = imax(imax(CSR_CYC, ASR_CYC), imax(RAS_CYC, PRE_CYC));
    localparam int TW = $clog2(LONGEST + 1);

    phase_e        ph;
    method_e       lat;
    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            tmr <= '0;
            lat <= METH_CBR;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (req && gnt) begin
                        lat <= meth;
                        if (meth == METH_ROR) begin
                            ph  <= PH_ADR;
                            tmr <= TW'(ASR_CYC - 1);
                        end else begin
                            ph  <= PH_CAS;
                            tmr <= TW'(CSR_CYC - 1);
                        end
                    end
                end
                PH_CAS, PH_ADR: begin
                    if (tmr == '0) begin
                        ph  <= PH_RAS;
                        tmr <= TW'(RAS_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_RAS: begin
                    if (tmr == '0) begin
                        ph  <= PH_PRE;
                        tmr <= TW'(PRE_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_PRE: begin
                    if (tmr == '0) ph <= PH_IDLE;
                    else           tmr <= tmr - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign pins     = pins_of(ph, lat);
    assign done     = (ph == PH_PRE) && (tmr == '0);
    assign ror_done = done && (lat == METH_ROR);
endmodule

// File: rtl/refsched_rowctr.sv
module refsched_rowctr #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)      row <= '0;
        else if (adv) row <= row + 1'b1;
    end
endmodule

// File: rtl/refsched_top.sv
module refsched_top
    import refsched_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int WIN_NS    = 64_000_000,
    parameter int CBR_ROWS  = 4096,
    parameter int ROR_ROWS  = 8192,
    parameter int CSR_CYC   = 1,
    parameter int ASR_CYC   = 1,
    parameter int RAS_CYC   = 3,
    parameter int RP_CYC    = 2,
    parameter int RC_CYC    = 5,
    parameter int ROW_W     = 13,
    parameter int BACKLOG_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_i,
    input  logic                 ref_gnt_i,
    output logic                 ref_req_o,
    output logic                 ref_urgent_o,
    output logic                 ref_done_o,
    output logic [BACKLOG_W-1:0] pending_o,
    output logic                 ras_n_o,
    output logic                 cas_n_o,
    output logic                 addr_oe_o,
    output logic [ROW_W-1:0]     addr_o
);
    localparam int INT_CBR = interval(WIN_NS, CBR_ROWS, CLK_NS);
    localparam int INT_ROR = interval(WIN_NS, ROR_ROWS, CLK_NS);
    localparam int PRE_CYC = imax(RP_CYC, RC_CYC - RAS_CYC - imin(CSR_CYC, ASR_CYC));

    method_e          meth;
    logic             tick;
    logic             done;
    logic             ror_done;
    pins_t            pins;
    logic [ROW_W-1:0] row;

    assign meth = method_e'(mode_i);

    refsched_timer #(.INT_CBR(INT_CBR), .INT_ROR(INT_ROR)) u_timer (
        .clk(clk), .rst(rst), .meth(meth), .tick(tick)
    );

    refsched_backlog #(.BW(BACKLOG_W)) u_backlog (
        .clk(clk), .rst(rst), .tick(tick), .done(done),
        .count(pending_o), .req(ref_req_o), .urgent(ref_urgent_o)
    );

    refsched_fsm #(
        .CSR_CYC(CSR_CYC), .ASR_CYC(ASR_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .req(ref_req_o), .gnt(ref_gnt_i), .meth(meth),
        .pins(pins), .done(done), .ror_done(ror_done)
    );

    refsched_rowctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .adv(ror_done), .row(row)
    );

    assign ref_done_o = done;
    assign ras_n_o    = pins.ras_n;
    assign cas_n_o    = pins.cas_n;
    assign addr_oe_o  = pins.addr_oe;
    assign addr_o     = pins.addr_oe ? row : '0;
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
    parameter int BACKLOG_W = 3,
    parameter int ROW_W     = 13
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ref_req_o,
    input logic                 ref_urgent_o,
    input logic                 ref_done_o,
    input logic [BACKLOG_W-1:0] pending_o,
    input logic                 ras_n_o,
    input logic                 cas_n_o,
    input logic                 addr_oe_o,
    input logic [ROW_W-1:0]     addr_o
);
    localparam logic [BACKLOG_W-1:0] FULL = '1;

    AST_BACKLOG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pending_o == FULL && !ref_done_o) |=> (pending_o == FULL)); // R2

    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (rst)
        ref_urgent_o |-> ref_req_o); // R3

    AST_NO_REQ_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!ref_req_o && ras_n_o && cas_n_o && !addr_oe_o)
        |=> (ras_n_o && cas_n_o && !addr_oe_o)); // R4

    AST_CAS_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o)); // R5

    AST_ROW_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (!ras_n_o && cas_n_o) |-> addr_oe_o); // R6

    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (rst)
        (addr_oe_o && $past(addr_oe_o)) |-> $stable(addr_o)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ref_done_o |=> !ref_done_o); // R8

    AST_DONE_PRECHARGED: assert property (@(posedge clk) disable iff (rst)
        ref_done_o |-> (ras_n_o && cas_n_o && !addr_oe_o && ref_req_o)); // R8
endmodule

bind refsched_top refsched_chk #(.BACKLOG_W(BACKLOG_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o),
    .ref_done_o(ref_done_o), .pending_o(pending_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .addr_oe_o(addr_oe_o), .addr_o(addr_o)
);

// File: tb/sim_refsched_top.sv
`timescale 1ns/1ps
module sim_refsched_top;
    // Bench configuration: internal interval 16, explicit interval 8, precharge 3
    localparam int B_CLK   = 20;
    localparam int B_WIN   = 4096 * 20 * 16;
    localparam int B_CSR   = 1;
    localparam int B_ASR   = 1;
    localparam int B_RAS   = 3;
    localparam int B_RP    = 2;
    localparam int B_RC    = 7;
    localparam int I_CBR   = B_WIN / (4096 * B_CLK);
    localparam int I_ROR   = B_WIN / (8192 * B_CLK);
    localparam int B_PRE   = (B_RP > B_RC - B_RAS - 1) ? B_RP : (B_RC - B_RAS - 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b0;
    logic        gnt = 1'b0;
    logic        req, urgent, done, ras_n, cas_n, oe;
    logic [2:0]  pending;
    logic [12:0] addr;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    // Reference model state
    int m_cnt = 0, m_back = 0, m_ph = 0, m_t = 0, m_row = 0;
    bit m_lat = 0;

    always #10 clk = ~clk;

    refsched_top #(
        .CLK_NS(B_CLK), .WIN_NS(B_WIN), .CBR_ROWS(4096), .ROR_ROWS(8192),
        .CSR_CYC(B_CSR), .ASR_CYC(B_ASR), .RAS_CYC(B_RAS), .RP_CYC(B_RP),
        .RC_CYC(B_RC), .ROW_W(13), .BACKLOG_W(3)
    ) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .ref_gnt_i(gnt),
        .ref_req_o(req), .ref_urgent_o(urgent), .ref_done_o(done),
        .pending_o(pending), .ras_n_o(ras_n), .cas_n_o(cas_n),
        .addr_oe_o(oe), .addr_o(addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_ras(); return (m_ph == 3) ? 0 : 1; endfunction
    function automatic int exp_cas(); return (m_ph == 1 || (m_ph == 3 && !m_lat)) ? 0 : 1; endfunction
    function automatic int exp_oe();  return (m_ph == 2 || (m_ph == 3 && m_lat)) ? 1 : 0; endfunction
    function automatic int exp_done(); return (m_ph == 4 && m_t == 0) ? 1 : 0; endfunction

    task automatic compare();
        chk("R3 req", int'(req), (m_back != 0) ? 1 : 0);
        chk("R3 urgent", int'(urgent), (m_back == 7) ? 1 : 0);
        chk("R1 R2 R8 pending", int'(pending), m_back);
        chk("R8 done", int'(done), exp_done());
        chk("R4 R5 R7 R11 ras_n", int'(ras_n), exp_ras());
        chk("R5 R6 R11 cas_n", int'(cas_n), exp_cas());
        chk("R6 R11 addr_oe", int'(oe), exp_oe());
        chk("R6 R9 addr", int'(addr), (exp_oe() == 1) ? m_row : 0);
    endtask

    // Predict the effect of the coming clock edge from the requirements
    task automatic model_adv();
        int  last = (mode ? I_ROR : I_CBR) - 1;
        bit  tk = (m_cnt >= last);
        bit  dn = (m_ph == 4 && m_t == 0);
        bit  rq = (m_back != 0);
        m_cnt = tk ? 0 : m_cnt + 1;
        if (tk && !dn && m_back < 7) m_back++;
        else if (dn && !tk && m_back > 0) m_back--;
        if (dn && m_lat) m_row = (m_row + 1) % 8192;
        case (m_ph)
            0: if (rq && gnt) begin
                   m_lat = mode;
                   m_ph  = mode ? 2 : 1;
                   m_t   = (mode ? B_ASR : B_CSR) - 1;
               end
            1, 2: if (m_t == 0) begin m_ph = 3; m_t = B_RAS - 1; end else m_t--;
            3:    if (m_t == 0) begin m_ph = 4; m_t = B_PRE - 1; end else m_t--;
            4:    if (m_t == 0) m_ph = 0; else m_t--;
            default: m_ph = 0;
        endcase
    endtask

    task automatic step(input logic g, input logic md);
        gnt  = g;
        mode = md;
        model_adv();
        @(negedge clk);
        compare();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: state under reset
        chk("R10 ras_n", int'(ras_n), 1);
        chk("R10 cas_n", int'(cas_n), 1);
        chk("R10 addr_oe", int'(oe), 0);
        chk("R10 addr", int'(addr), 0);
        chk("R10 req", int'(req), 0);
        chk("R10 urgent", int'(urgent), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 pending", int'(pending), 0);
        rst = 1'b0;

        // R1 R2: no grant, backlog climbs every interval then saturates at 7
        for (int i = 0; i < 9 * I_CBR; i++) step(1'b0, 1'b0);
        chk("R2 saturated", int'(pending), 7);

        // R4 R11: grant and method change arrive at random, also mid-refresh
        for (int i = 0; i < 4000; i++) begin
            logic md;
            md = mode;
            if (($urandom % 16) == 0) md = ~md;
            step(($urandom % 4) != 0, md);
        end

        // R9: explicit-row refresh runs long enough to wrap the row number
        for (int i = 0; i < 70000; i++) step(1'b1, 1'b1);

        // R5: internal-counter refresh with constant grant
        for (int i = 0; i < 2000; i++) step(1'b1, 1'b0);

        // R7: grant withdrawn mid-refresh has no effect on the waveform
        for (int i = 0; i < 500; i++) step(($urandom % 2) == 0, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end
endmodule